// File: doc/BRIEF.md
# Character LCD Command Sequencer

This block drives a parallel character display over an 8-bit data bus, a register-select line and an enable strobe. A one-cycle start request makes it write four command bytes to the display. It then goes idle and takes character bytes from a valid/ready stream. Each accepted character is written with register-select set to data.

Every write follows the same timeline. The bus and register-select are driven first, and the setup period runs. The enable strobe is then high for the pulse period. After the strobe falls, the hold period runs, followed by a wait period before the next write may begin. The four periods come from input ports, counted in clock cycles. The block samples them at the moment a write is launched. It does not read back from the display, so the wait period must cover the display's execution time.

Top module: `lcd_cmd_seq`

## Requirements
- R1: While rst is high, and on the first cycle after it is released, lcd_en, lcd_rs and lcd_db are 0, and both busy and ch_ready are 0.
- R2: A start pulse in the uninitialised state launches initialisation. busy is 1 from the cycle after that start until the last initialisation write has finished.
- R3: Initialisation writes four command bytes with lcd_rs=0, in this order: 8'h01 (clear), 8'h33 (function set), 8'h0C (display on), 8'h06 (entry mode).
- R4: Counting from the cycle after launch, every write has four periods: lcd_en low for S cycles, high for P cycles, low for H cycles, then low for a further G cycles. S, P, H and G are cfg_setup, cfg_pulse, cfg_hold and cfg_gap as sampled at launch, and a value of 0 counts as 1.
- R5: lcd_db and lcd_rs change only when a write is launched. They hold their values through all four periods and afterwards, until the next launch.
- R6: ch_ready is 1 only in the idle state after initialisation, and busy is 0 there.
- R7: A byte on ch_data is accepted on a cycle where ch_valid and ch_ready are both 1. It is written with lcd_rs=1, and from the next cycle ch_ready is 0 and busy is 1 until the write's wait period ends.
- R8: ch_valid has no effect on the display pins while ch_ready is 0, whether the block is uninitialised, initialising or writing a character.
- R9: A start pulse is ignored while initialisation runs and after it has completed.
- R10: The next initialisation write is launched on the last wait cycle of the previous one. The idle state, with ch_ready=1, is reached the cycle after the last wait cycle of the final command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to run the initialisation script |
| cfg_setup | input | CNT_W | Setup period in cycles (0 counts as 1) |
| cfg_pulse | input | CNT_W | Enable high period in cycles (0 counts as 1) |
| cfg_hold | input | CNT_W | Hold period in cycles (0 counts as 1) |
| cfg_gap | input | CNT_W | Wait period after hold in cycles (0 counts as 1) |
| ch_valid | input | 1 | Character byte offered |
| ch_data | input | 8 | Character byte |
| ch_ready | output | 1 | Sequencer can take a character |
| busy | output | 1 | Initialisation or a character write in progress |
| lcd_rs | output | 1 | Register select: 0 command, 1 character |
| lcd_en | output | 1 | Enable strobe |
| lcd_db | output | 8 | Display data bus |

## Verification
The bench sweeps several timing sets, including all-zero periods that must stretch to one cycle, and compares every pin in every cycle of every write against a timeline computed from the sampled periods. A timer with an off-by-one error in one period would shift the enable edge and fail the per-cycle comparison. So would a chain that left an idle cycle between commands, or one that started the next command a cycle early. Characters are offered while the block is uninitialised, while it is initialising and while it is writing. A block that honoured valid without ready would put the stray byte on the bus or start an extra strobe. Repeated start pulses check that a second start does not restart the script.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    localparam int DB_W     = 8;
    localparam int INIT_LEN = 4;
    localparam int IDX_W    = $clog2(INIT_LEN);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_GAP
    } phase_t;

    typedef enum logic [1:0] {
        SQ_COLD,
        SQ_INIT,
        SQ_READY,
        SQ_CHAR
    } seq_t;

    typedef struct packed {
        logic            rs;
        logic [DB_W-1:0] db;
    } bus_word_t;

    function automatic logic [DB_W-1:0] script_byte(input logic [IDX_W-1:0] idx);
        logic [DB_W-1:0] b;
        case (idx)
            2'd0:    b = 8'h01;
            2'd1:    b = 8'h33;
            2'd2:    b = 8'h0C;
            default: b = 8'h06;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lcd_init_rom.sv
module lcd_init_rom
    import lcd_seq_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output logic [DB_W-1:0]  cmd
);
    always_comb cmd = script_byte(idx);
endmodule

// File: rtl/lcd_strobe_timer.sv
module lcd_strobe_timer
    import lcd_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  bus_word_t        word_in,
    input  logic [CNT_W-1:0] len_setup,
    input  logic [CNT_W-1:0] len_pulse,
    input  logic [CNT_W-1:0] len_hold,
    input  logic [CNT_W-1:0] len_gap,
    output bus_word_t        word_out,
    output logic             en,
    output logic             done
);
    localparam int NPH = 4;

    phase_t           phase, phase_nxt;
    logic [CNT_W-1:0] cnt, cur_len;
    logic [CNT_W-1:0] lens [NPH];
    logic [CNT_W-1:0] cfg  [NPH];
    logic             last, launch;
    bus_word_t        word_q;
    logic             en_q;

    assign cfg[0] = len_setup;
    assign cfg[1] = len_pulse;
    assign cfg[2] = len_hold;
    assign cfg[3] = len_gap;

    always_comb begin
        case (phase)
            PH_SETUP:  cur_len = lens[0];
            PH_STROBE: cur_len = lens[1];
            PH_HOLD:   cur_len = lens[2];
            PH_GAP:    cur_len = lens[3];
            default:   cur_len = '0;
        endcase
    end

    assign last   = (phase != PH_IDLE) && (cnt == cur_len - 1'b1);
    assign done   = (phase == PH_GAP) && last;
    assign launch = go && ((phase == PH_IDLE) || done);

    always_comb begin
        phase_nxt = phase;
        if (launch) begin
            phase_nxt = PH_SETUP;
        end else if (last) begin
            case (phase)
                PH_SETUP:  phase_nxt = PH_STROBE;
                PH_STROBE: phase_nxt = PH_HOLD;
                PH_HOLD:   phase_nxt = PH_GAP;
                default:   phase_nxt = PH_IDLE;
            endcase
        end
    end

    generate
        for (genvar i = 0; i < NPH; i++) begin : g_len
            always_ff @(posedge clk) begin
                if (rst)
                    lens[i] <= '0;
                else if (launch)
                    lens[i] <= (cfg[i] == '0) ? CNT_W'(1) : cfg[i];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            word_q <= '0;
            en_q   <= 1'b0;
        end else begin
            phase <= phase_nxt;
            en_q  <= (phase_nxt == PH_STROBE);
            if (launch) begin
                word_q <= word_in;
                cnt    <= '0;
            end else if (last) begin
                cnt <= '0;
            end else if (phase != PH_IDLE) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign word_out = word_q;
    assign en       = en_q;
endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
    import lcd_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            ch_valid,
    input  logic [DB_W-1:0] ch_data,
    input  logic            done,
    input  logic [DB_W-1:0] rom_cmd,
    output logic [IDX_W-1:0] rom_idx,
    output logic            go,
    output bus_word_t       word,
    output logic            ch_ready,
    output logic            busy
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(INIT_LEN - 1);

    seq_t             st;
    logic [IDX_W-1:0] idx;

    assign rom_idx = (st == SQ_COLD) ? '0 : idx + 1'b1;

    always_comb begin
        go   = 1'b0;
        word = '0;
        case (st)
            SQ_COLD: if (start) begin
                go   = 1'b1;
                word = '{rs: 1'b0, db: rom_cmd};
            end
            SQ_INIT: if (done && idx != LAST_IDX) begin
                go   = 1'b1;
                word = '{rs: 1'b0, db: rom_cmd};
            end
            SQ_READY: if (ch_valid) begin
                go   = 1'b1;
                word = '{rs: 1'b1, db: ch_data};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SQ_COLD;
            idx <= '0;
        end else begin
            case (st)
                SQ_COLD: if (start) begin
                    st  <= SQ_INIT;
                    idx <= '0;
                end
                SQ_INIT: if (done) begin
                    if (idx == LAST_IDX) st <= SQ_READY;
                    else                 idx <= idx + 1'b1;
                end
                SQ_READY: if (ch_valid) st <= SQ_CHAR;
                default:  if (done) st <= SQ_READY;
            endcase
        end
    end

    assign ch_ready = (st == SQ_READY);
    assign busy     = (st == SQ_INIT) || (st == SQ_CHAR);
endmodule

// File: rtl/lcd_cmd_seq.sv
module lcd_cmd_seq
    import lcd_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] cfg_setup,
    input  logic [CNT_W-1:0] cfg_pulse,
    input  logic [CNT_W-1:0] cfg_hold,
    input  logic [CNT_W-1:0] cfg_gap,
    input  logic             ch_valid,
    input  logic [7:0]       ch_data,
    output logic             ch_ready,
    output logic             busy,
    output logic             lcd_rs,
    output logic             lcd_en,
    output logic [7:0]       lcd_db
);
    logic             go, done;
    bus_word_t        word_go, word_bus;
    logic [IDX_W-1:0] rom_idx;
    logic [DB_W-1:0]  rom_cmd;

    lcd_init_rom i_rom (
        .idx (rom_idx),
        .cmd (rom_cmd)
    );

    lcd_seq_ctrl i_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .ch_valid (ch_valid),
        .ch_data  (ch_data),
        .done     (done),
        .rom_cmd  (rom_cmd),
        .rom_idx  (rom_idx),
        .go       (go),
        .word     (word_go),
        .ch_ready (ch_ready),
        .busy     (busy)
    );

    lcd_strobe_timer #(.CNT_W(CNT_W)) i_timer (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .word_in   (word_go),
        .len_setup (cfg_setup),
        .len_pulse (cfg_pulse),
        .len_hold  (cfg_hold),
        .len_gap   (cfg_gap),
        .word_out  (word_bus),
        .en        (lcd_en),
        .done      (done)
    );

    assign lcd_rs = word_bus.rs;
    assign lcd_db = word_bus.db;
endmodule

// File: rtl/lcd_seq_checker.sv
module lcd_seq_checker (
    input logic       clk,
    input logic       rst,
    input logic       ch_valid,
    input logic       ch_ready,
    input logic       busy,
    input logic       lcd_rs,
    input logic       lcd_en,
    input logic [7:0] lcd_db
);
    // R5: bus steady while the strobe is high
    p_bus_steady_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        (lcd_en && $past(lcd_en)) |-> ($stable(lcd_db) && $stable(lcd_rs)));

    // R4: setup of at least one cycle before the strobe rises
    p_setup_before_rise_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(lcd_en) |-> ($stable(lcd_db) && $stable(lcd_rs)));

    // R5: hold after the strobe falls
    p_hold_after_fall_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(lcd_en) |=> ($stable(lcd_db) && $stable(lcd_rs) && !lcd_en));

    // R6: ready and busy never together
    p_ready_not_busy_r6: assert property (@(posedge clk) disable iff (rst)
        ch_ready |-> !busy);

    // R7: a handshake drops ready and raises busy
    p_accept_drops_ready_r7: assert property (@(posedge clk) disable iff (rst)
        (ch_valid && ch_ready) |=> (!ch_ready && busy && lcd_rs));

    // R6: no strobe while idle
    p_idle_no_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        ch_ready |-> !lcd_en);
endmodule

bind lcd_cmd_seq lcd_seq_checker i_lcd_seq_checker (
    .clk      (clk),
    .rst      (rst),
    .ch_valid (ch_valid),
    .ch_ready (ch_ready),
    .busy     (busy),
    .lcd_rs   (lcd_rs),
    .lcd_en   (lcd_en),
    .lcd_db   (lcd_db)
);

// File: tb/test_lcd_cmd_seq.sv
module test_lcd_cmd_seq;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [CW-1:0] cfg_setup = '0, cfg_pulse = '0, cfg_hold = '0, cfg_gap = '0;
    logic          ch_valid = 1'b0;
    logic [7:0]    ch_data = '0;
    logic          ch_ready, busy, lcd_rs, lcd_en;
    logic [7:0]    lcd_db;

    int errs = 0, checks = 0;
    int eS, eP, eH, eG;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    lcd_cmd_seq #(.CNT_W(CW)) i_lcd_cmd_seq (
        .clk(clk), .rst(rst), .start(start),
        .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse),
        .cfg_hold(cfg_hold), .cfg_gap(cfg_gap),
        .ch_valid(ch_valid), .ch_data(ch_data),
        .ch_ready(ch_ready), .busy(busy),
        .lcd_rs(lcd_rs), .lcd_en(lcd_en), .lcd_db(lcd_db)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // called at the negedge of the first setup cycle; returns at the
    // negedge right after the last wait cycle
    task automatic run_xfer(input logic [7:0] b, input logic rs, input string tag);
        int total = eS + eP + eH + eG;
        for (int c = 0; c < total; c++) begin
            chk({"R4 en ", tag}, lcd_en, (c >= eS && c < eS + eP) ? 1 : 0);
            chk({"R5 db ", tag}, lcd_db, b);
            chk({"R5 rs ", tag}, lcd_rs, rs);
            chk({"R7 busy ", tag}, busy, 1);
            chk({"R8 ready ", tag}, ch_ready, 0);
            @(negedge clk);
        end
    endtask

    task automatic run_config(input int s, input int p, input int h, input int g);
        logic [7:0] script [4];
        script[0] = 8'h01; script[1] = 8'h33; script[2] = 8'h0C; script[3] = 8'h06;
        eS = (s == 0) ? 1 : s; eP = (p == 0) ? 1 : p;
        eH = (h == 0) ? 1 : h; eG = (g == 0) ? 1 : g;
        cfg_setup = CW'(s); cfg_pulse = CW'(p); cfg_hold = CW'(h); cfg_gap = CW'(g);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 en in reset", lcd_en, 0);
        chk("R1 db in reset", lcd_db, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 en", lcd_en, 0);
        chk("R1 db", lcd_db, 0);
        chk("R1 rs", lcd_rs, 0);
        chk("R1 busy", busy, 0);
        chk("R1 ready", ch_ready, 0);
        // R8: valid while uninitialised
        ch_valid = 1'b1; ch_data = 8'h5A;
        repeat (3) begin
            @(negedge clk);
            chk("R8 cold en", lcd_en, 0);
            chk("R8 cold db", lcd_db, 0);
            chk("R8 cold busy", busy, 0);
        end
        ch_valid = 1'b0;
        start = 1'b1;
        @(negedge clk);
        chk("R2 busy after start", busy, 1);
        for (int k = 0; k < 4; k++) begin
            // R9: start held during first command; R8: valid during second
            if (k == 1) begin start = 1'b0; ch_valid = 1'b1; ch_data = 8'h77; end
            if (k == 2) ch_valid = 1'b0;
            run_xfer(script[k], 1'b0, $sformatf("R3 R10 cmd%0d", k));
        end
        chk("R10 ready after init", ch_ready, 1);
        chk("R6 busy idle", busy, 0);
        chk("R6 en idle", lcd_en, 0);
        // R9: start after init
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) begin
            @(negedge clk);
            chk("R9 busy", busy, 0);
            chk("R9 ready", ch_ready, 1);
            chk("R9 en", lcd_en, 0);
            chk("R9 db", lcd_db, 8'h06);
        end
        for (int k = 0; k < 3; k++) begin
            logic [7:0] d = 8'h41 + 8'(k * 7 + s);
            ch_valid = 1'b1; ch_data = d;
            @(negedge clk);
            ch_valid = 1'b0;
            chk("R7 ready drops", ch_ready, 0);
            if (k == 1) begin ch_valid = 1'b1; ch_data = 8'hEE; end
            run_xfer(d, 1'b1, $sformatf("R7 char%0d", k));
            ch_valid = 1'b0;
            chk("R6 ready after char", ch_ready, 1);
            chk("R6 busy after char", busy, 0);
        end
        @(negedge clk);
        chk("R8 no stray write en", lcd_en, 0);
        chk("R8 no stray write busy", busy, 0);
    endtask

    initial begin
        run_config(1, 1, 1, 1);
        run_config(2, 3, 1, 4);
        run_config(0, 2, 0, 0);
        run_config(3, 1, 2, 2);
        run_config(0, 0, 0, 0);
        run_config(5, 4, 3, 6);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errs++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule